// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block keeps the pending, in-service and trigger-kind state for 256 interrupt vectors that belong to one processor. It decides whether any pending vector may interrupt the processor now, and it raises an interrupt-request line when one may. When the processor acknowledges, the block hands over the chosen vector and moves it from pending to in service. When the processor signals end of interrupt, the block retires the most important vector in service. If that vector was level-triggered, the block sends a one-cycle broadcast pulse carrying the retired vector, so that the interrupt source can re-arm.

Priority is graded in classes, and a vector's class is its upper four bits. A processor priority combines the programmed task priority with the class of the most important vector in service. A pending vector whose class does not exceed that priority waits. An acknowledge given in that state returns a programmable spurious vector and changes nothing.

Top module: `lipc_top`

## Requirements
- R1: After reset no vector is pending or in service, the task priority is 0, the spurious register holds vector 0xFF with the software-enable bit clear, `irq` is 0, `ppr` is 0, and `ack_vec` reads 0xFF.
- R2: A set request with vector v marks v pending and records its trigger kind (level when `set_level` is 1, edge otherwise). A later set of the same vector overwrites the recorded kind.
- R3: Among pending vectors the highest-numbered one is offered, and among in-service vectors the highest-numbered one counts as the current one.
- R4: `ppr` equals the task priority when the task-priority class (bits 7:4) is greater than or equal to the class of the highest in-service vector. Otherwise `ppr` is that class followed by four zero bits. An empty in-service set counts as vector 0.
- R5: `irq` is 1 exactly when the software-enable bit is set, some vector is pending, and the offered vector is not blocked. A vector is blocked when `ppr` is nonzero and the vector's class is less than or equal to the class of `ppr`. `irq` follows the state in the same cycle.
- R6: An acknowledge while `irq` is 1 returns the offered vector on `ack_vec` in the same cycle. From the next clock that vector is in service and no longer pending.
- R7: An acknowledge while `irq` is 0 returns the low 8 bits of the spurious register on `ack_vec` and changes no state.
- R8: A spurious-register write keeps data bits 7:0 (spurious vector), bit 8 (software enable) and bit 12 (broadcast suppression). It discards every other bit.
- R9: An end-of-interrupt strobe clears the highest in-service vector at the next clock. If that vector was recorded as level-triggered and suppression is clear, `eoi_bcast` is 1 for exactly that one cycle and `eoi_bcast_vec` carries the vector. In every other case `eoi_bcast` stays 0.
- R10: An end-of-interrupt strobe with no vector in service changes nothing and gives no broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_vld | input | 1 | Request a vector |
| set_vec | input | 8 | Vector being requested |
| set_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority write data |
| svr_wr | input | 1 | Spurious-register write strobe |
| svr_wdata | input | 16 | Spurious-register write data |
| ack | input | 1 | Acknowledge strobe from the processor |
| eoi | input | 1 | End-of-interrupt strobe |
| irq | output | 1 | Interrupt request to the processor |
| ack_vec | output | 8 | Vector returned for the current acknowledge |
| ppr | output | 8 | Processor priority |
| eoi_bcast | output | 1 | One-cycle broadcast pulse for a retired level vector |
| eoi_bcast_vec | output | 8 | Vector carried by the broadcast pulse |

## Verification
Every one of the 256 vectors is requested alone and then acknowledged and retired, alternating edge and level kinds. This sweep separates errors in the bit-index encoders and in the class-derived `ppr`, and checks that the broadcast follows the recorded kind. A second sweep crosses all 16 task-priority classes with all 16 request classes, which pins down the less-or-equal blocking boundary and the spurious return. Directed sequences cover nested in-service vectors, the in-service class blocking its own class, re-kinding a vector, suppression, disable, the discarding of spurious-register bits, and retiring from an empty in-service set.

// File: rtl/lipc_pkg.sv
package lipc_pkg;
    localparam int SVR_VEC_W   = 8;
    localparam int SVR_EN_BIT  = 8;
    localparam int SVR_SUP_BIT = 12;
    localparam int CLASS_W     = 4;

    typedef struct packed {
        logic                 sup;
        logic                 en;
        logic [SVR_VEC_W-1:0] vec;
    } svr_t;
endpackage

// File: rtl/lipc_word_enc.sv
module lipc_word_enc #(
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] bits,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (bits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lipc_hi_enc.sv
module lipc_hi_enc #(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    localparam int N_WORDS = NUM_VEC / WORD_W,
    localparam int IDX_W   = $clog2(WORD_W),
    localparam int SEL_W   = $clog2(N_WORDS),
    localparam int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic [NUM_VEC-1:0] bits,
    output logic               any,
    output logic [VEC_W-1:0]   vec
);
    logic [N_WORDS-1:0] w_any;
    logic [IDX_W-1:0]   w_idx [N_WORDS];

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        lipc_word_enc #(.WORD_W(WORD_W)) u_enc (
            .bits (bits[w*WORD_W +: WORD_W]),
            .any  (w_any[w]),
            .idx  (w_idx[w])
        );
    end

    always_comb begin
        any = 1'b0;
        vec = '0;
        for (int w = 0; w < N_WORDS; w++) begin
            if (w_any[w]) begin
                any = 1'b1;
                vec = {SEL_W'(w), w_idx[w]};
            end
        end
    end
endmodule

// File: rtl/lipc_ppr.sv
module lipc_ppr #(
    parameter int VEC_W = 8,
    localparam int CW = lipc_pkg::CLASS_W
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_any,
    input  logic [VEC_W-1:0] isr_vec,
    output logic [VEC_W-1:0] ppr
);
    logic [CW-1:0] isr_cls;

    always_comb begin
        isr_cls = isr_any ? isr_vec[VEC_W-1 -: CW] : '0;
        if (tpr[VEC_W-1 -: CW] >= isr_cls)
            ppr = tpr;
        else
            ppr = {isr_cls, {(VEC_W-CW){1'b0}}};
    end
endmodule

// File: rtl/lipc_top.sv
module lipc_top #(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int CW     = lipc_pkg::CLASS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_vld,
    input  logic [VEC_W-1:0] set_vec,
    input  logic             set_level,
    input  logic             tpr_wr,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             svr_wr,
    input  logic [15:0]      svr_wdata,
    input  logic             ack,
    input  logic             eoi,
    output logic             irq,
    output logic [VEC_W-1:0] ack_vec,
    output logic [VEC_W-1:0] ppr,
    output logic             eoi_bcast,
    output logic [VEC_W-1:0] eoi_bcast_vec
);
    import lipc_pkg::*;

    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        logic [NUM_VEC-1:0] tmr;
        logic [VEC_W-1:0]   tpr;
        svr_t               svr;
        logic               bc_vld;
        logic [VEC_W-1:0]   bc_vec;
    } state_t;

    state_t st_d, st_q;

    logic             irr_any, isr_any, blocked;
    logic [VEC_W-1:0] irr_vec, isr_vec;

    lipc_hi_enc #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_irr_enc (
        .bits (st_q.irr), .any (irr_any), .vec (irr_vec)
    );

    lipc_hi_enc #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_isr_enc (
        .bits (st_q.isr), .any (isr_any), .vec (isr_vec)
    );

    lipc_ppr #(.VEC_W(VEC_W)) u_ppr (
        .tpr (st_q.tpr), .isr_any (isr_any), .isr_vec (isr_vec), .ppr (ppr)
    );

    always_comb begin
        blocked = (ppr != '0) && (irr_vec[VEC_W-1 -: CW] <= ppr[VEC_W-1 -: CW]);
        irq     = st_q.svr.en && irr_any && !blocked;
        ack_vec = irq ? irr_vec : st_q.svr.vec;
    end

    always_comb begin
        st_d        = st_q;
        st_d.bc_vld = 1'b0;
        if (eoi && isr_any) begin
            st_d.isr[isr_vec] = 1'b0;
            st_d.bc_vec       = isr_vec;
            st_d.bc_vld       = st_q.tmr[isr_vec] && !st_q.svr.sup;
        end
        if (ack && irq) begin
            st_d.irr[irr_vec] = 1'b0;
            st_d.isr[irr_vec] = 1'b1;
        end
        if (set_vld) begin
            st_d.irr[set_vec] = 1'b1;
            st_d.tmr[set_vec] = set_level;
        end
        if (tpr_wr)
            st_d.tpr = tpr_wdata;
        if (svr_wr) begin
            st_d.svr.sup = svr_wdata[SVR_SUP_BIT];
            st_d.svr.en  = svr_wdata[SVR_EN_BIT];
            st_d.svr.vec = svr_wdata[SVR_VEC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.svr.vec <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign eoi_bcast     = st_q.bc_vld;
    assign eoi_bcast_vec = st_q.bc_vec;
endmodule

// File: rtl/lipc_chk.sv
module lipc_chk #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             eoi,
    input logic             irq,
    input logic [VEC_W-1:0] ack_vec,
    input logic [VEC_W-1:0] ppr,
    input logic             eoi_bcast,
    input logic [VEC_W-1:0] tpr_q,
    input logic             svr_en_q,
    input logic             isr_any
);
    // R6
    ack_class_raises_ppr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq) |=> (ppr[VEC_W-1 -: 4] >= $past(ack_vec[VEC_W-1 -: 4])));

    // R5
    granted_above_ppr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq) |-> (ppr == '0 || ack_vec[VEC_W-1 -: 4] > ppr[VEC_W-1 -: 4]));

    // R5
    no_irq_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !svr_en_q |-> !irq);

    // R4
    ppr_not_below_tpr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ppr >= tpr_q);

    // R9
    bcast_after_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast |-> $past(eoi));

    // R10
    empty_eoi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !isr_any) |=> !eoi_bcast);
endmodule

bind lipc_top lipc_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .eoi       (eoi),
    .irq       (irq),
    .ack_vec   (ack_vec),
    .ppr       (ppr),
    .eoi_bcast (eoi_bcast),
    .tpr_q     (st_q.tpr),
    .svr_en_q  (st_q.svr.en),
    .isr_any   (isr_any)
);

// File: tb/sim_lipc_top.sv
module sim_lipc_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_vld = 1'b0, set_level = 1'b0;
    logic [7:0] set_vec = '0;
    logic       tpr_wr = 1'b0;
    logic [7:0] tpr_wdata = '0;
    logic       svr_wr = 1'b0;
    logic [15:0] svr_wdata = '0;
    logic       ack = 1'b0, eoi = 1'b0;
    logic       irq, eoi_bcast;
    logic [7:0] ack_vec, ppr, eoi_bcast_vec;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lipc_top u0 (
        .clk(clk), .rst_n(rst_n), .set_vld(set_vld), .set_vec(set_vec),
        .set_level(set_level), .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
        .svr_wr(svr_wr), .svr_wdata(svr_wdata), .ack(ack), .eoi(eoi),
        .irq(irq), .ack_vec(ack_vec), .ppr(ppr), .eoi_bcast(eoi_bcast),
        .eoi_bcast_vec(eoi_bcast_vec)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_set(input logic [7:0] v, input logic lvl);
        set_vld = 1'b1; set_vec = v; set_level = lvl;
        step();
        set_vld = 1'b0;
    endtask

    task automatic do_tpr(input logic [7:0] v);
        tpr_wr = 1'b1; tpr_wdata = v;
        step();
        tpr_wr = 1'b0;
    endtask

    task automatic do_svr(input logic [15:0] v);
        svr_wr = 1'b1; svr_wdata = v;
        step();
        svr_wr = 1'b0;
    endtask

    task automatic do_ack(input string tag, input int exp);
        ack = 1'b1;
        #1;
        chk(tag, ack_vec, exp);
        step();
        ack = 1'b0;
    endtask

    task automatic do_eoi(input string tag, input bit exp_b, input int exp_v);
        eoi = 1'b1;
        step();
        eoi = 1'b0;
        chk(tag, eoi_bcast, exp_b);
        if (exp_b) chk(tag, eoi_bcast_vec, exp_v);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 ppr", ppr, 0);
        chk("R1 bcast", eoi_bcast, 0);
        do_ack("R1 ack_vec", 8'hFF);

        // R8 upper bits dropped, vector/enable kept
        do_svr(16'hE13A);
        do_ack("R8 spurious vector", 8'h3A);

        // Sweep all vectors, alternating trigger kind: R2 R3 R4 R6 R9
        for (int v = 0; v < 256; v++) begin
            do_set(8'(v), v[0]);
            chk("R5 irq single", irq, 1);
            do_ack("R6 ack single", v);
            chk("R4 ppr in service", ppr, (v >> 4) << 4);
            chk("R6 not pending", irq, 0);
            do_eoi("R9 kind broadcast", v[0], v);
            chk("R4 ppr idle", ppr, 0);
        end

        // Task class vs request class: R5 R7
        for (int t = 0; t < 16; t++) begin
            for (int c = 0; c < 16; c++) begin
                do_tpr(8'((t << 4) | 3));
                do_set(8'((c << 4) | 5), 1'b0);
                chk("R5 class block", irq, (c > t) ? 1 : 0);
                chk("R4 ppr tpr", ppr, (t << 4) | 3);
                if (c > t) begin
                    do_ack("R6 ack above", (c << 4) | 5);
                end else begin
                    do_ack("R7 blocked spurious", 8'h3A);
                    do_tpr(8'h00);
                    do_ack("R7 state kept", (c << 4) | 5);
                end
                do_eoi("R9 edge quiet", 0, 0);
            end
        end
        do_tpr(8'h00);

        // R3 highest pending offered, own class blocks
        do_set(8'h40, 1'b0);
        do_set(8'h41, 1'b0);
        do_set(8'h90, 1'b1);
        do_ack("R3 highest first", 8'h90);
        chk("R5 lower class blocked", irq, 0);
        do_ack("R7 spurious under 0x90", 8'h3A);
        do_eoi("R9 level 0x90", 1, 8'h90);
        do_ack("R3 next 0x41", 8'h41);
        chk("R5 same class blocked", irq, 0);
        do_eoi("R9 edge 0x41", 0, 0);
        do_ack("R6 then 0x40", 8'h40);
        do_eoi("R9 edge 0x40", 0, 0);

        // Nested in service, highest retired first
        do_set(8'h30, 1'b0);
        do_ack("R6 nest low", 8'h30);
        do_set(8'h80, 1'b1);
        chk("R5 nest irq", irq, 1);
        do_ack("R6 nest high", 8'h80);
        chk("R4 ppr nest", ppr, 8'h80);
        do_eoi("R9 retire 0x80", 1, 8'h80);
        chk("R3 ppr after retire", ppr, 8'h30);
        do_eoi("R9 retire 0x30", 0, 0);
        do_eoi("R10 empty eoi", 0, 0);
        chk("R10 ppr unchanged", ppr, 0);
        chk("R10 irq unchanged", irq, 0);

        // R4 tpr vs in-service class
        do_tpr(8'h52);
        do_set(8'h70, 1'b0);
        do_ack("R6 0x70", 8'h70);
        chk("R4 isr class wins", ppr, 8'h70);
        do_eoi("R9 0x70", 0, 0);
        chk("R4 tpr back", ppr, 8'h52);
        do_tpr(8'h00);

        // R2 re-kind: level then edge
        do_set(8'hC7, 1'b1);
        do_set(8'hC7, 1'b0);
        do_ack("R2 rekind ack", 8'hC7);
        do_eoi("R2 rekind edge quiet", 0, 0);

        // R8 suppression bit kept
        do_svr(16'h113A);
        do_set(8'hA1, 1'b1);
        do_ack("R8 ack sup", 8'hA1);
        do_eoi("R8 suppressed", 0, 0);

        // R5 disabled: no irq, spurious returned, state kept
        do_svr(16'h0055);
        do_set(8'h66, 1'b1);
        chk("R5 disabled irq", irq, 0);
        do_ack("R7 disabled ack", 8'h55);
        do_svr(16'h0155);
        chk("R5 enabled irq", irq, 1);
        do_ack("R7 kept pending", 8'h66);
        do_eoi("R9 level after enable", 1, 8'h66);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule